// File: doc/BRIEF.md
# Binary-Field Inverter by Repeated Squaring

This block computes the multiplicative inverse of an element of GF(2^10), with the field defined by the polynomial x^10 + x^3 + 1. It raises the operand to the power 2^10 − 2 one step per clock. The operand register is squared in place. Each new power is multiplied into a chain of nine ten-bit scratch registers, and the last of these ends up holding the inverse.

Once the answer is latched into the result register, the block runs the same sequence backwards. It takes inverse squarings (square roots) of the operand register and XORs each product back into the scratch register it came from. At the end of this pass the operand register holds the original value again, and every scratch register except the last is zero. The caller pulses start with an operand, watches busy, and reads the result when done pulses. An operand of zero yields zero.

Top module: `gfinv_exp`

## Requirements
- R1: After reset, busy and done are low and result is all zeros.
- R2: For every nonzero operand A, the result r satisfies A·r = 1 in GF(2^10) modulo x^10 + x^3 + 1. Bit i of operand and result is the coefficient of x^i.
- R3: An operand of zero yields a result of zero.
- R4: done goes high exactly 36 clock cycles after the rising edge that samples start in the idle state. busy is high from that edge until the done cycle. Each square, inverse square, copy or multiply takes one clock.
- R5: done is high for exactly one cycle per operation.
- R6: A start request is ignored while busy is high and during the done cycle. The running operation completes with the first operand's result, and no second operation begins.
- R7: result changes only at the capture step of an operation. It holds its value through done and through idle cycles until the next operation's capture.
- R8: When done is high, the operand register holds the original operand again and scratch registers 0 to 7 are zero. A following operation therefore starts from clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an inversion, sampled only when idle |
| operand | input | 10 | Field element to invert, sampled together with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the operation and the cleanup pass are complete |
| result | output | 10 | Inverse of the last operand, valid from done onward |

## Verification
The two events that can land in the same cycle are a fresh start request and a block that is still occupied. The request may arrive during the forward or reverse pass, or in the very cycle that done is high. The bench raises start with a different operand at a random step inside the run, or exactly on the done cycle. It then judges that done still arrives 36 cycles after the original start, that the result inverts the first operand, and that busy stays low afterwards. Because the operations run back to back across every operand value, any scratch state left dirty by a preceding cleanup pass would show up as a wrong inverse in the next operation.

// File: rtl/gfinv_pkg.sv
`timescale 1ns/1ps
package gfinv_pkg;

  // One strobe per datapath action; the controller raises at most one per cycle.
  typedef struct packed {
    logic load;   // take operand, clear the result-holding scratch slot
    logic sq;     // square operand register in place
    logic isq;    // square root of operand register in place
    logic copy;   // XOR operand register into scratch slot 0
    logic mac;    // XOR operand*scr[idx-2] into scr[idx-1]
    logic cap;    // latch the last scratch slot into result
    logic fin;    // done cycle
  } stepCmd_t;

endpackage

// File: rtl/gf_squarer.sv
`timescale 1ns/1ps
module gf_squarer #(
  parameter int             W       = 10,
  parameter logic [W-1:0]   POLY    = 10'h009,
  parameter bit             INVERSE = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  // Spread bits to even positions, then fold the upper half down with the polynomial.
  function automatic logic [W-1:0] sqOnce(input logic [W-1:0] a);
    logic [2*W-2:0] v;
    v = '0;
    for (int i = 0; i < W; i++) v[2*i] = a[i];
    for (int k = 2*W-2; k >= W; k--) begin
      if (v[k]) begin
        v[k] = 1'b0;
        v[k-W +: W] = v[k-W +: W] ^ POLY;
      end
    end
    return v[W-1:0];
  endfunction

  generate
    if (!INVERSE) begin : g_fwd
      assign dout = sqOnce(din);
    end else begin : g_inv
      // Square root equals raising to 2^(W-1): W-1 chained squarings.
      logic [W-1:0] stage [W];
      assign stage[0] = din;
      for (genvar g = 1; g < W; g++) begin : g_chain
        assign stage[g] = sqOnce(stage[g-1]);
      end
      assign dout = stage[W-1];
    end
  endgenerate

endmodule

// File: rtl/gf_mul.sv
`timescale 1ns/1ps
module gf_mul #(
  parameter int           W    = 10,
  parameter logic [W-1:0] POLY = 10'h009
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);

  logic [W-1:0] acc;
  logic [W-1:0] sh;

  always_comb begin
    acc = '0;
    sh  = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[W-1] ? ((sh << 1) ^ POLY) : (sh << 1);
    end
    p = acc;
  end

endmodule

// File: rtl/gfinv_ctrl.sv
`timescale 1ns/1ps
module gfinv_ctrl
  import gfinv_pkg::*;
#(
  parameter int W  = 10,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output stepCmd_t      cmd,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);

  typedef enum logic [3:0] {
    S_IDLE, S_FSQ0, S_FCOPY, S_FSQ, S_FMAC, S_CAP,
    S_RISQ, S_RMAC, S_TISQ1, S_TCOPY, S_TISQ2, S_DONE
  } ctlState_t;

  localparam logic [IW-1:0] IDX_FIRST = IW'(2);
  localparam logic [IW-1:0] IDX_LAST  = IW'(W-1);
  localparam logic [IW-1:0] IDX_REV   = IW'(W-2);

  ctlState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_FSQ0;
        S_FSQ0:  state <= S_FCOPY;
        S_FCOPY: begin idx <= IDX_FIRST; state <= S_FSQ; end
        S_FSQ:   state <= S_FMAC;
        S_FMAC: begin
          if (idx == IDX_LAST) state <= S_CAP;
          else begin idx <= idx + IW'(1); state <= S_FSQ; end
        end
        S_CAP:   begin idx <= IDX_REV; state <= S_RISQ; end
        S_RISQ:  state <= S_RMAC;
        S_RMAC: begin
          if (idx == IDX_FIRST) state <= S_TISQ1;
          else begin idx <= idx - IW'(1); state <= S_RISQ; end
        end
        S_TISQ1: state <= S_TCOPY;
        S_TCOPY: state <= S_TISQ2;
        S_TISQ2: state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd = '0;
    case (state)
      S_IDLE:                   cmd.load = start;
      S_FSQ0, S_FSQ:            cmd.sq   = 1'b1;
      S_FCOPY, S_TCOPY:         cmd.copy = 1'b1;
      S_FMAC, S_RMAC:           cmd.mac  = 1'b1;
      S_CAP:                    cmd.cap  = 1'b1;
      S_RISQ, S_TISQ1, S_TISQ2: cmd.isq  = 1'b1;
      S_DONE:                   cmd.fin  = 1'b1;
      default:                  cmd      = '0;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  // R4
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.load, cmd.sq, cmd.isq, cmd.copy, cmd.mac, cmd.cap, cmd.fin}));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  run_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/gfinv_dpath.sv
`timescale 1ns/1ps
module gfinv_dpath
  import gfinv_pkg::*;
#(
  parameter int           W    = 10,
  parameter logic [W-1:0] POLY = 10'h009,
  parameter int           IW   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  stepCmd_t      cmd,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  operand,
  output logic [W-1:0]  result
);

  localparam int NSCR = W - 1;

  logic [W-1:0]  opReg;
  logic [W-1:0]  sqOut;
  logic [W-1:0]  isqOut;
  logic [W-1:0]  mulOut;
  logic [W-1:0]  mulSrc;
  logic [W-1:0]  scr [NSCR];
  logic [IW-1:0] srcSel;
  logic [IW-1:0] tgtSel;

  assign srcSel = idx - IW'(2);
  assign tgtSel = idx - IW'(1);
  assign mulSrc = scr[srcSel];

  gf_squarer #(.W(W), .POLY(POLY), .INVERSE(1'b0)) u_sq (
    .din (opReg),
    .dout(sqOut)
  );

  gf_squarer #(.W(W), .POLY(POLY), .INVERSE(1'b1)) u_isq (
    .din (opReg),
    .dout(isqOut)
  );

  gf_mul #(.W(W), .POLY(POLY)) u_mul (
    .a(opReg),
    .b(mulSrc),
    .p(mulOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         opReg <= '0;
    else if (cmd.load) opReg <= operand;
    else if (cmd.sq)   opReg <= sqOut;
    else if (cmd.isq)  opReg <= isqOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NSCR; g++) scr[g] <= '0;
    end else begin
      if (cmd.load) scr[NSCR-1] <= '0;
      if (cmd.copy) scr[0]      <= scr[0] ^ opReg;
      if (cmd.mac)  scr[tgtSel] <= scr[tgtSel] ^ mulOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        result <= '0;
    else if (cmd.cap) result <= scr[NSCR-1];
  end

  // Checking aids: copy of the loaded operand and a flag for leftover scratch bits.
  logic [W-1:0] opShadow;
  logic         scrDirty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         opShadow <= '0;
    else if (cmd.load) opShadow <= operand;
  end

  always_comb begin
    scrDirty = 1'b0;
    for (int g = 0; g < NSCR-1; g++) scrDirty = scrDirty | (|scr[g]);
  end

  // R8
  operand_restored_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fin |-> (opReg == opShadow));

  // R8
  scratch_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fin |-> !scrDirty);

  // R2
  result_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fin |-> (result == scr[NSCR-1]));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.cap |=> $stable(result));

endmodule

// File: rtl/gfinv_exp.sv
`timescale 1ns/1ps
module gfinv_exp
  import gfinv_pkg::*;
#(
  parameter int           W    = 10,
  parameter logic [W-1:0] POLY = 10'h009
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] operand,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int IW = $clog2(W);

  stepCmd_t      cmd;
  logic [IW-1:0] idx;

  gfinv_ctrl #(.W(W), .IW(IW)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .cmd  (cmd),
    .idx  (idx),
    .busy (busy),
    .done (done)
  );

  gfinv_dpath #(.W(W), .POLY(POLY), .IW(IW)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .idx    (idx),
    .operand(operand),
    .result (result)
  );

endmodule

// File: tb/gfinv_exp_tb.sv
`timescale 1ns/1ps
module gfinv_exp_tb;

  localparam int W       = 10;
  localparam int LATENCY = 36;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] operand = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gfinv_exp u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .operand(operand),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  // Reference: carry-less product, then long division by x^10 + x^3 + 1.
  function automatic logic [W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-2:0] prod;
    prod = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) prod = prod ^ ((2*W-1)'(a) << i);
    for (int k = 2*W-2; k >= W; k--)
      if (prod[k]) prod = prod ^ ((2*W-1)'(11'b10000001001) << (k - W));
    return prod[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: plain run; 1: extra start while busy; 2: extra start in the done cycle
  task automatic runOne(input logic [W-1:0] a, input int mode, input bit later);
    int cnt;
    int lat;
    int poke;
    logic [W-1:0] held;
    poke = int'($urandom % (LATENCY - 1));
    @(negedge clk);
    operand = a;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    operand = ~a;
    cnt = 0;
    lat = -1;
    while (cnt < 3 * LATENCY) begin
      if (done) begin lat = cnt; break; end
      if (cnt == 0) check(busy == 1'b1, "R4 busy after start", int'(busy), 1);
      if (mode == 1 && cnt == poke) begin
        start = 1'b1;
        operand = a ^ 10'h155;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(lat == LATENCY, "R4 latency", lat, LATENCY);
    check(busy == 1'b0, "R4 busy low at done", int'(busy), 0);
    if (a == '0)
      check(result == '0, "R3 zero operand", int'(result), 0);
    else if (later)
      check(refMul(a, result) == 10'd1, "R2 R8 inverse after prior run", int'(refMul(a, result)), 1);
    else
      check(refMul(a, result) == 10'd1, "R2 inverse", int'(refMul(a, result)), 1);
    held = result;
    if (mode == 2) begin
      start = 1'b1;
      operand = a ^ 10'h2AA;
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R5 done one cycle", int'(done), 0);
    if (mode != 0)
      check(busy == 1'b0, "R6 extra start ignored", int'(busy), 0);
    @(negedge clk);
    check(result == held, "R7 result holds", int'(result), int'(held));
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy == 1'b0,   "R1 busy at reset", int'(busy), 0);
    check(done == 1'b0,   "R1 done at reset", int'(done), 0);
    check(result == '0,   "R1 result at reset", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 idle after release", int'(busy), 0);

    // Directed corners
    runOne(10'd0,   0, 1'b0);
    runOne(10'd1,   0, 1'b1);
    runOne(10'h3FF, 2, 1'b1);
    runOne(10'h200, 1, 1'b1);
    runOne(10'd0,   2, 1'b1);

    // Sweep every operand value, interleaving the interference modes
    for (int v = 1; v < (1 << W); v++)
      runOne(W'(v), int'($urandom % 3), 1'b1);

    // Random operands
    for (int n = 0; n < 200; n++)
      runOne(W'($urandom), int'($urandom % 3), 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule